// File: doc/BRIEF.md
# I2C Bus Error Status Logic

This block keeps the sticky error and event flags of an I2C peripheral, together with its clock-control register. It samples the raw SCL and SDA lines through a synchroniser and looks for START conditions (SDA falls while SCL stays high) and STOP conditions (SDA rises while SCL stays high). It also takes the byte-engine's bit position. If a START or STOP arrives while that position is not at a byte boundary, the bus-error flag is set. The byte engine also supplies single-cycle strobes for lost arbitration and for a matched general-call address.

Software reads the status register and reads or writes the clock-control register through a small CPU port. Each flag follows its own clearing rule:

- Arbitration-lost and bus-error clear when the status register is read.
- General-call clears only when a STOP is seen.
- All three flags drop while the peripheral is disabled.
- The clock settings are kept while the peripheral is disabled.

Towards the engine, the block drives three signals:

- an interrupt request;
- a one-cycle pulse that forces the engine back to slave mode;
- a release level that forbids the engine from stretching SCL while an error flag is pending.

Top module: `i2c_errstat`

## Requirements
- R1: After reset, the status register reads 00h, the clock-control register reads 00h, and `irq`, `to_slave` and `scl_release` are 0.
- R2: A write with `cpu_addr`=1 loads the clock-control register, which reads back at `cpu_addr`=1. Bit 7 drives `clk_fast` (1 = fast mode, 0 = standard mode) and bits 6:0 drive `clk_div`.
- R3: The clock-control register keeps its value while `periph_en` is 0, and it can still be written in that state.
- R4: A START or STOP seen while `bit_pos` is nonzero (1 to 8 are data bits, 9 is the acknowledge bit) sets the bus-error flag in status bit 1. A START or STOP seen while `bit_pos` is 0 leaves that flag unchanged. A line change reaches the flag on the third rising clock edge after it is sampled.
- R5: An `arb_lost_evt` strobe while enabled does two things in the following cycle: it sets the arbitration-lost flag in status bit 2, and it drives `to_slave` high for exactly one cycle.
- R6: A read strobe with `cpu_addr`=0 clears the arbitration-lost and bus-error flags. If a set event occurs in the same cycle as the read, the flag ends at 1.
- R7: A `gcall_evt` strobe sets the general-call flag in status bit 0 only while `gcall_en` is 1. A status read does not clear this flag. A STOP clears it, and a START does not.
- R8: While `periph_en` is 0, all three status flags are 0, and event strobes and misplaced conditions have no effect.
- R9: `irq` is 1 exactly when `irq_en` is 1 and either the arbitration-lost flag or the bus-error flag is set. The general-call flag does not raise `irq`.
- R10: `scl_release` is 1 exactly when the arbitration-lost flag or the bus-error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 clears the flags |
| irq_en | input | 1 | Interrupt enable |
| gcall_en | input | 1 | Enables recognition of the general-call address |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| bit_pos | input | BITCNT_W | Engine bit position; 0 is the byte boundary |
| arb_lost_evt | input | 1 | Strobe: arbitration lost |
| gcall_evt | input | 1 | Strobe: general-call address matched |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 1 | 0 selects status, 1 selects clock control |
| cpu_wdata | input | DIV_W+1 | Write data |
| cpu_rdata | output | DIV_W+1 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| to_slave | output | 1 | One-cycle pulse forcing slave mode |
| scl_release | output | 1 | Engine must not hold SCL low |
| clk_fast | output | 1 | Fast-mode select |
| clk_div | output | DIV_W | Clock divider value |

## Verification
START and STOP conditions are generated with `bit_pos` at 0, at a data bit and at the acknowledge bit. This separates legal framing from misplaced framing, and separates a START from a STOP when judging the general-call clear. Status reads are issued alone, together with a new event in the same cycle, and while only the general-call flag is pending. These cases distinguish the clear-on-read flags from the one that clears only on STOP, and show that a set event wins over a simultaneous read. Disabling the peripheral while flags are pending, and while events keep arriving, separates state that is wiped on disable from the clock settings, which are kept.

// File: rtl/i2c_errstat_pkg.sv
package i2c_errstat_pkg;
    localparam int ST_GCAL = 0;
    localparam int ST_BERR = 1;
    localparam int ST_ARLO = 2;

    typedef struct packed {
        logic arlo;
        logic berr;
        logic gcal;
        logic to_slave;
    } flag_state_t;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] scl_chain;
        logic [LAST:0] sda_chain;
        logic          scl_prev;
        logic          sda_prev;
    } watch_t;

    watch_t watch_d, watch_q;
    logic   scl_s, sda_s;

    assign scl_s = watch_q.scl_chain[LAST];
    assign sda_s = watch_q.sda_chain[LAST];

    always_comb begin
        watch_d           = watch_q;
        watch_d.scl_chain = {watch_q.scl_chain[LAST-1:0], scl_raw};
        watch_d.sda_chain = {watch_q.sda_chain[LAST-1:0], sda_raw};
        watch_d.scl_prev  = scl_s;
        watch_d.sda_prev  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) watch_q <= '1;
        else        watch_q <= watch_d;
    end

    assign start_det = scl_s & watch_q.scl_prev & watch_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & watch_q.scl_prev & ~watch_q.sda_prev & sda_s;
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_errstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rd_status,
    input  logic arb_evt,
    input  logic gcall_evt,
    input  logic gcall_en,
    input  logic misplaced,
    input  logic stop_seen,
    output logic arlo,
    output logic berr,
    output logic gcal,
    output logic to_slave
);
    flag_state_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (!enable) begin
            flags_d = '0;
        end else begin
            flags_d.to_slave = arb_evt;
            flags_d.arlo     = arb_evt | (flags_q.arlo & ~rd_status);
            flags_d.berr     = misplaced | (flags_q.berr & ~rd_status);
            flags_d.gcal     = (gcall_evt & gcall_en) | (flags_q.gcal & ~stop_seen);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign arlo     = flags_q.arlo;
    assign berr     = flags_q.berr;
    assign gcal     = flags_q.gcal;
    assign to_slave = flags_q.to_slave;
endmodule

// File: rtl/i2c_clkctl_reg.sv
module i2c_clkctl_reg #(
    parameter int DIV_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [DIV_W:0] wdata,
    output logic [DIV_W:0] value
);
    typedef struct packed {
        logic             fast;
        logic [DIV_W-1:0] div;
    } clkctl_t;

    clkctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = clkctl_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign value = ctl_q;
endmodule

// File: rtl/i2c_errstat.sv
module i2c_errstat
    import i2c_errstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BITCNT_W    = 4,
    parameter int DIV_W       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                periph_en,
    input  logic                irq_en,
    input  logic                gcall_en,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [BITCNT_W-1:0] bit_pos,
    input  logic                arb_lost_evt,
    input  logic                gcall_evt,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic                cpu_addr,
    input  logic [DIV_W:0]      cpu_wdata,
    output logic [DIV_W:0]      cpu_rdata,
    output logic                irq,
    output logic                to_slave,
    output logic                scl_release,
    output logic                clk_fast,
    output logic [DIV_W-1:0]    clk_div
);
    localparam int REG_W = DIV_W + 1;

    logic             start_det, stop_det, misplaced;
    logic             st_arlo, st_berr, st_gcal;
    logic [REG_W-1:0] ctl_value;
    logic [REG_W-1:0] status_word;

    i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign misplaced = (start_det | stop_det) & (bit_pos != '0);

    i2c_flag_bank u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (periph_en),
        .rd_status (cpu_rd & ~cpu_addr),
        .arb_evt   (arb_lost_evt),
        .gcall_evt (gcall_evt),
        .gcall_en  (gcall_en),
        .misplaced (misplaced),
        .stop_seen (stop_det),
        .arlo      (st_arlo),
        .berr      (st_berr),
        .gcal      (st_gcal),
        .to_slave  (to_slave)
    );

    i2c_clkctl_reg #(.DIV_W(DIV_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr & cpu_addr),
        .wdata (cpu_wdata),
        .value (ctl_value)
    );

    always_comb begin
        status_word          = '0;
        status_word[ST_GCAL] = st_gcal;
        status_word[ST_BERR] = st_berr;
        status_word[ST_ARLO] = st_arlo;
    end

    assign cpu_rdata   = cpu_addr ? ctl_value : status_word;
    assign scl_release = st_arlo | st_berr;
    assign irq         = irq_en & scl_release;
    assign clk_fast    = ctl_value[DIV_W];
    assign clk_div     = ctl_value[DIV_W-1:0];
endmodule

// File: rtl/i2c_errstat_chk.sv
module i2c_errstat_chk #(
    parameter int BITCNT_W = 4,
    parameter int DIV_W    = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                periph_en,
    input logic                irq_en,
    input logic                arb_lost_evt,
    input logic                cpu_rd,
    input logic                cpu_wr,
    input logic                cpu_addr,
    input logic [BITCNT_W-1:0] bit_pos,
    input logic                start_det,
    input logic                stop_det,
    input logic                st_arlo,
    input logic                st_berr,
    input logic                st_gcal,
    input logic                irq,
    input logic                to_slave,
    input logic                clk_fast,
    input logic [DIV_W-1:0]    clk_div
);
    logic rd_sr;
    assign rd_sr = cpu_rd & ~cpu_addr;

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (!st_arlo && !st_berr && !st_gcal && !to_slave));

    p_arlo_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && arb_lost_evt) |=> (st_arlo && to_slave));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && rd_sr && !arb_lost_evt) |=> !st_arlo);

    p_gcal_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && st_gcal && !stop_det) |=> st_gcal);

    p_misplaced_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && (start_det || stop_det) && bit_pos != '0) |=> st_berr);

    p_ctl_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr) |=> $stable({clk_fast, clk_div}));

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

bind i2c_errstat i2c_errstat_chk #(.BITCNT_W(BITCNT_W), .DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .periph_en    (periph_en),
    .irq_en       (irq_en),
    .arb_lost_evt (arb_lost_evt),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .bit_pos      (bit_pos),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .st_arlo      (st_arlo),
    .st_berr      (st_berr),
    .st_gcal      (st_gcal),
    .irq          (irq),
    .to_slave     (to_slave),
    .clk_fast     (clk_fast),
    .clk_div      (clk_div)
);

// File: tb/i2c_errstat_bench.sv
module i2c_errstat_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_en = 1'b0, irq_en = 1'b0, gcall_en = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic [3:0] bit_pos = 4'd0;
    logic       arb_lost_evt = 1'b0, gcall_evt = 1'b0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq, to_slave, scl_release, clk_fast;
    logic [6:0] clk_div;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    i2c_errstat u_i2c_errstat (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .irq_en(irq_en),
        .gcall_en(gcall_en), .scl_in(scl_in), .sda_in(sda_in), .bit_pos(bit_pos),
        .arb_lost_evt(arb_lost_evt), .gcall_evt(gcall_evt), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq), .to_slave(to_slave),
        .scl_release(scl_release), .clk_fast(clk_fast), .clk_div(clk_div)
    );

    // Behavioural reference model
    bit   scl_h[$];
    bit   sda_h[$];
    bit   m_arlo, m_berr, m_gcal, m_slave;
    logic [7:0] m_ctl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arlo = 0; m_berr = 0; m_gcal = 0; m_slave = 0; m_ctl = 8'h00;
            scl_h = '{1, 1, 1};
            sda_h = '{1, 1, 1};
        end else begin
            bit st, sp, rd;
            st = scl_h[1] && scl_h[2] && sda_h[2] && !sda_h[1];
            sp = scl_h[1] && scl_h[2] && !sda_h[2] && sda_h[1];
            rd = cpu_rd && !cpu_addr;
            if (cpu_wr && cpu_addr) m_ctl = cpu_wdata;
            if (!periph_en) begin
                m_arlo = 0; m_berr = 0; m_gcal = 0; m_slave = 0;
            end else begin
                m_slave = arb_lost_evt;
                m_arlo  = arb_lost_evt || (m_arlo && !rd);
                m_berr  = ((st || sp) && bit_pos != 0) || (m_berr && !rd);
                m_gcal  = (gcall_evt && gcall_en) || (m_gcal && !sp);
            end
            scl_h.push_front(scl_in); void'(scl_h.pop_back());
            sda_h.push_front(sda_in); void'(sda_h.pop_back());
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        #2;
        if (rst_n) begin
            logic [7:0] exp_rd;
            exp_rd = cpu_addr ? m_ctl : {5'b0, m_arlo, m_berr, m_gcal};
            check("R2/R4/R5/R6/R7/R8 rdata", cpu_rdata, exp_rd);
            check("R9 irq", {7'b0, irq}, {7'b0, irq_en && (m_arlo || m_berr)});
            check("R10 scl_release", {7'b0, scl_release}, {7'b0, m_arlo || m_berr});
            check("R5 to_slave", {7'b0, to_slave}, {7'b0, m_slave});
            check("R2 R3 ctl outputs", {clk_fast, clk_div}, m_ctl);
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic addr, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = addr;
        #1 v = cpu_rdata;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        cpu_addr = 1; cpu_wr = 1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic read_status();
        @(negedge clk);
        cpu_addr = 0; cpu_rd = 1;
        @(negedge clk);
        cpu_rd = 0;
    endtask

    task automatic pulse_arb();
        @(negedge clk);
        arb_lost_evt = 1;
        @(negedge clk);
        arb_lost_evt = 0;
    endtask

    task automatic pulse_gcall();
        @(negedge clk);
        gcall_evt = 1;
        @(negedge clk);
        gcall_evt = 0;
    endtask

    task automatic set_sda(input logic v);
        @(negedge clk);
        sda_in = v;
        ticks(5);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        ticks(4);
        rst_n = 1;
        // R1 reset state
        peek(0, v); check("R1 status", v, 8'h00);
        peek(1, v); check("R1 ctl", v, 8'h00);
        check("R1 irq/to_slave/release", {irq, to_slave, scl_release}, 8'h00);

        // R2 clock-control write and read
        write_ctl(8'h85);
        peek(1, v); check("R2 ctl 85", v, 8'h85);
        check("R2 fast", {7'b0, clk_fast}, 8'h01);
        check("R2 div", {1'b0, clk_div}, 8'h05);
        write_ctl(8'h3C);
        check("R2 fast off", {clk_fast, clk_div}, 8'h3C);

        periph_en = 1;
        ticks(5);
        // R4 START at boundary is legal
        set_sda(0);
        peek(0, v); check("R4 legal start", v, 8'h00);
        // R4 misplaced STOP mid-byte
        bit_pos = 4'd5;
        set_sda(1);
        peek(0, v); check("R4 misplaced stop", v, 8'h02);
        check("R10 release on berr", {7'b0, scl_release}, 8'h01);
        check("R9 irq masked", {7'b0, irq}, 8'h00);
        irq_en = 1;
        #1 check("R9 irq enabled", {7'b0, irq}, 8'h01);
        read_status();
        peek(0, v); check("R6 read clears berr", v, 8'h00);
        check("R9 irq drops", {7'b0, irq}, 8'h00);
        // R4 misplaced START during acknowledge bit
        bit_pos = 4'd9;
        set_sda(0);
        peek(0, v); check("R4 start in ack", v, 8'h02);
        read_status();
        bit_pos = 4'd0;
        set_sda(1);
        peek(0, v); check("R4 legal stop", v, 8'h00);

        // R5 arbitration lost
        @(negedge clk); cpu_addr = 0; arb_lost_evt = 1;
        @(negedge clk); arb_lost_evt = 0;
        #1 check("R5 to_slave pulse", {7'b0, to_slave}, 8'h01);
        check("R5 arlo set", cpu_rdata, 8'h04);
        @(negedge clk);
        #1 check("R5 pulse one cycle", {7'b0, to_slave}, 8'h00);
        // R6 set wins over same-cycle read
        @(negedge clk); cpu_rd = 1; arb_lost_evt = 1;
        @(negedge clk); cpu_rd = 0; arb_lost_evt = 0;
        #1 check("R6 set wins", cpu_rdata, 8'h04);
        read_status();
        peek(0, v); check("R6 read clears arlo", v, 8'h00);

        // R7 general call
        gcall_en = 0;
        pulse_gcall();
        peek(0, v); check("R7 ignored when disabled", v, 8'h00);
        gcall_en = 1;
        pulse_gcall();
        peek(0, v); check("R7 gcal set", v, 8'h01);
        check("R9 gcal no irq", {7'b0, irq}, 8'h00);
        read_status();
        peek(0, v); check("R7 read keeps gcal", v, 8'h01);
        set_sda(0);
        peek(0, v); check("R7 start keeps gcal", v, 8'h01);
        set_sda(1);
        peek(0, v); check("R7 stop clears gcal", v, 8'h00);

        // R8 disable clears; R3 ctl kept
        pulse_gcall();
        pulse_arb();
        peek(0, v); check("R8 flags before disable", v, 8'h05);
        periph_en = 0;
        ticks(2);
        peek(0, v); check("R8 disable clears", v, 8'h00);
        peek(1, v); check("R3 ctl kept", v, 8'h3C);
        pulse_arb();
        pulse_gcall();
        bit_pos = 4'd4;
        set_sda(0);
        set_sda(1);
        peek(0, v); check("R8 events ignored", v, 8'h00);
        check("R8 no pulse", {7'b0, to_slave}, 8'h00);
        write_ctl(8'hFF);
        peek(1, v); check("R3 write while disabled", v, 8'hFF);
        periph_en = 1;
        bit_pos = 4'd0;
        ticks(5);
        finish_run();
    end
endmodule